// File: doc/BRIEF.md
# Serial-Controlled ADC Conversion Sequencer

This block is the digital core of a serial-interfaced successive-approximation converter, seen from the converter side. A host shifts a control byte in on the data input while chip select is low. The block waits for the first 1 bit, which marks the start of the frame. It then runs the track/hold and bit-search phases and returns the result serially, most significant bit first. A one-bit comparator decision comes back from the analog side for each trial word the block presents. Channel and input-mode fields are passed on to the analog multiplexer.

The serial clock, chip select and data input are treated as asynchronous. They are brought into the system clock domain before any decoding. Two clocking schemes share the same shift interface. In the first, the serial clock itself paces the bit search. In the second, a divided system clock runs the search and the host reads the stored result afterwards. The block also handles back-to-back frames, and a chip-select toggle lets the host cancel a conversion that is still running.

Top module: `adc_seq_top`

## Requirements
- R1: While chip select is low, 0 bits on `din` before the first 1 are ignored. The first 1 sampled on an `sclk` rising edge is bit 7 of the control byte, and the byte is received MSB first. Its fields are: bit 7 start; bits 6:4 channel; bit 3 unipolar (1) or bipolar (0); bit 2 single-ended (1) or differential (0); bit 1 awake flag; bit 0 clock source (1 = serial clock paces the search, 0 = internal clock).
- R2: On the `sclk` falling edge that follows the eighth control bit, the fields appear on the `cfg_*` outputs and the conversion starts.
- R3: `track` rises on the falling edge after the sixth control bit and falls on the falling edge after the eighth bit.
- R4: With serial-clock pacing, `strobe` is high for the two falling-edge periods that follow the eighth bit. The next eight falling edges place the result on `dout`, MSB first. After that, `dout` reads 0.
- R5: With serial-clock pacing, `strobe_oe` and `dout_oe` are low while chip select is high. Once chip select falls, `strobe` drives 0.
- R6: With internal pacing, `strobe` drops when the conversion starts and rises when the eight-step search ends, after about 8*INT_DIV system clocks. `strobe_oe` stays high.
- R7: With internal pacing, the conversion completes even if chip select is raised, and `dout_oe` then follows chip select. On the second `sclk` falling edge after `strobe` rises, `dout` shows the MSB. The remaining bits follow, then zeros.
- R8: The bit search returns an offset code equal to the analog level. In unipolar mode that code is output unchanged (straight binary). In bipolar mode its MSB is inverted, giving two's complement.
- R9: A new start bit is accepted only when no conversion is running, or once the current MSB has been driven on `dout`. A 1 bit arriving earlier is ignored. This allows one conversion every ten `sclk` cycles.
- R10: If chip select falls again while a conversion is still running and its MSB has not been driven, the next 1 bit on `din` starts a new control byte. The running conversion is discarded.
- R11: `din` and `sclk` have no effect while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock (asynchronous) |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| din | input | 1 | Serial control input (asynchronous) |
| cmp_hi | input | 1 | Comparator: analog level is at or above `dac_trial` |
| dac_trial | output | RES_W | Trial word presented to the capacitive DAC |
| track | output | 1 | Track/hold is in tracking mode |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Drive enable for `dout` |
| strobe | output | 1 | Conversion strobe |
| strobe_oe | output | 1 | Drive enable for `strobe` |
| cfg_chan | output | 3 | Selected channel field |
| cfg_single | output | 1 | Single-ended mode selected |
| cfg_unipolar | output | 1 | Unipolar coding selected |
| cfg_awake | output | 1 | Awake flag from the control byte |
| cfg_ext_clk | output | 1 | Serial clock paces the search |

## Verification
A receiver that locks onto the wrong start bit misaligns the whole frame. The wrong channel or mode then appears on `cfg_*` at the very next falling edge, and the strobe fires one or more `sclk` periods early or late. A fault in the search or in the polarity handling shows as a wrong `dout` bit within the eight falling edges that follow. A fault in the arming or cancel logic shows up a whole frame later. The new byte is either dropped or taken from the middle of a result, so the strobe and configuration seen after the next eight clocks are wrong.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_EXT,
    PH_INT_RUN,
    PH_INT_OUT
  } phase_e;

  typedef struct packed {
    logic [2:0] chan;
    logic       unipolar;
    logic       single;
    logic       awake;
    logic       ext_clk;
  } ctrl_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int            N   = 1,
  parameter logic [N-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= RST[g];
        stab <= RST[g];
      end else begin
        meta <= d[g];
        stab <= meta;
      end
    end
    assign q[g] = stab;
  end
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         stop,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] trial,
  output logic         busy,
  output logic         first,
  output logic         done
);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      trial <= '0;
      mask  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        trial <= TOP;
        mask  <= TOP;
        busy  <= 1'b1;
      end else if (stop) begin
        busy <= 1'b0;
      end else if (step && busy) begin
        trial <= (cmp ? trial : (trial & ~mask)) | (mask >> 1);
        mask  <= mask >> 1;
        if (mask[0]) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign first = mask[W-1];

  AST_STEP_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    step |-> busy); // R4
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int RES_W   = 8,
  parameter int INT_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             din,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] dac_trial,
  output logic             track,
  output logic             dout,
  output logic             dout_oe,
  output logic             strobe,
  output logic             strobe_oe,
  output logic [2:0]       cfg_chan,
  output logic             cfg_single,
  output logic             cfg_unipolar,
  output logic             cfg_awake,
  output logic             cfg_ext_clk
);
  import adc_seq_pkg::*;

  localparam int FC_W  = $clog2(RES_W + 3);
  localparam int DIV_W = $clog2(INT_DIV + 1);

  // input capture: {din, cs_n, sclk}
  logic [2:0] sy;
  adc_seq_sync #(.N(3), .RST(3'b010)) i_sync (
    .clk(clk), .rst(rst), .d({din, cs_n, sclk}), .q(sy)
  );

  logic sclk_s, cs_s, din_s, sclk_p, cs_p;
  assign sclk_s = sy[0];
  assign cs_s   = sy[1];
  assign din_s  = sy[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= 1'b0;
      cs_p   <= 1'b1;
    end else begin
      sclk_p <= sclk_s;
      cs_p   <= cs_s;
    end
  end

  logic sck_r, sck_f, cs_fall;
  assign sck_r   = sclk_s & ~sclk_p & ~cs_s;
  assign sck_f   = ~sclk_s & sclk_p & ~cs_s;
  assign cs_fall = ~cs_s & cs_p;

  // conversion state
  phase_e           phase;
  ctrl_t            cfg, pend;
  logic             pend_v, trk_pend, collecting, msb_out, cs_tog;
  logic [2:0]       rcnt;
  logic [5:0]       rsr;
  logic [FC_W-1:0]  fcnt;
  logic [1:0]       ofc;
  logic [RES_W-1:0] osr;
  logic [DIV_W-1:0] divc;

  logic armed, start_acc, abort, conv_go, ext_step, int_tick;
  logic sar_busy, sar_first, sar_done;

  assign armed     = (phase == PH_IDLE) | msb_out | cs_tog;
  assign start_acc = sck_r & ~collecting & din_s & armed;
  assign abort     = start_acc & cs_tog & (phase != PH_IDLE) & ~msb_out;
  assign conv_go   = sck_f & pend_v;
  assign ext_step  = sck_f & ~pend_v & (phase == PH_EXT) & (fcnt >= FC_W'(2));
  assign int_tick  = (phase == PH_INT_RUN) & (divc == DIV_W'(INT_DIV - 1));

  adc_seq_sar #(.W(RES_W)) i_sar (
    .clk(clk), .rst(rst), .start(conv_go), .stop(abort),
    .step(ext_step | int_tick), .cmp(cmp_hi),
    .trial(dac_trial), .busy(sar_busy), .first(sar_first), .done(sar_done)
  );

  // control byte receiver
  always_ff @(posedge clk) begin
    if (rst) begin
      collecting <= 1'b0;
      rcnt       <= '0;
      rsr        <= '0;
      pend       <= '0;
      pend_v     <= 1'b0;
      trk_pend   <= 1'b0;
      track      <= 1'b0;
    end else if (cs_s) begin
      collecting <= 1'b0;
      pend_v     <= 1'b0;
      trk_pend   <= 1'b0;
    end else begin
      if (sck_r) begin
        if (!collecting) begin
          if (din_s && armed) begin
            collecting <= 1'b1;
            rcnt       <= '0;
          end
        end else begin
          rsr  <= {rsr[4:0], din_s};
          rcnt <= rcnt + 3'd1;
          if (rcnt == 3'd4) trk_pend <= 1'b1;
          if (rcnt == 3'd6) begin
            collecting <= 1'b0;
            pend_v     <= 1'b1;
            pend       <= ctrl_t'({rsr, din_s});
          end
        end
      end
      if (sck_f) begin
        if (trk_pend) begin
          track    <= 1'b1;
          trk_pend <= 1'b0;
        end
        if (pend_v) begin
          track  <= 1'b0;
          pend_v <= 1'b0;
        end
      end
    end
  end

  // conversion phases and output shifting
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cfg     <= ctrl_t'(7'b0000001);
      strobe  <= 1'b0;
      dout    <= 1'b0;
      fcnt    <= '0;
      ofc     <= '0;
      osr     <= '0;
      msb_out <= 1'b0;
      cs_tog  <= 1'b0;
      divc    <= '0;
    end else begin
      if (cs_fall) begin
        if (phase != PH_IDLE) cs_tog <= 1'b1;
        if (cfg.ext_clk) strobe <= 1'b0;
      end
      if (start_acc) cs_tog <= 1'b0;
      if (abort) begin
        phase <= PH_IDLE;
        dout  <= 1'b0;
      end
      if (conv_go) begin
        cfg     <= pend;
        msb_out <= 1'b0;
        fcnt    <= FC_W'(1);
        divc    <= '0;
        dout    <= 1'b0;
        phase   <= pend.ext_clk ? PH_EXT : PH_INT_RUN;
        strobe  <= pend.ext_clk;
      end else if (sck_f) begin
        case (phase)
          PH_EXT: begin
            fcnt <= fcnt + FC_W'(1);
            if (fcnt == FC_W'(2)) strobe <= 1'b0;
            if (ext_step) begin
              dout <= cmp_hi ^ (sar_first & ~cfg.unipolar);
              if (sar_first) msb_out <= 1'b1;
            end
            if (fcnt == FC_W'(RES_W + 1)) phase <= PH_IDLE;
          end
          PH_INT_OUT: begin
            if (ofc != 2'd2) ofc <= ofc + 2'd1;
            if (ofc == 2'd1) begin
              dout    <= osr[RES_W-1];
              osr     <= osr << 1;
              msb_out <= 1'b1;
            end else if (ofc == 2'd2) begin
              dout <= osr[RES_W-1];
              osr  <= osr << 1;
            end else begin
              dout <= 1'b0;
            end
          end
          default: dout <= 1'b0;
        endcase
      end
      if (phase == PH_INT_RUN && !conv_go) begin
        divc <= int_tick ? '0 : divc + DIV_W'(1);
        if (sar_done) begin
          phase  <= PH_INT_OUT;
          strobe <= 1'b1;
          ofc    <= '0;
          osr    <= {dac_trial[RES_W-1] ^ ~cfg.unipolar, dac_trial[RES_W-2:0]};
        end
      end
    end
  end

  assign dout_oe      = ~cs_s;
  assign strobe_oe    = ~cfg.ext_clk | ~cs_s;
  assign cfg_chan     = cfg.chan;
  assign cfg_single   = cfg.single;
  assign cfg_unipolar = cfg.unipolar;
  assign cfg_awake    = cfg.awake;
  assign cfg_ext_clk  = cfg.ext_clk;

  AST_HOLD_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(sar_busy) |-> !track); // R3
  AST_EXT_STROBE_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    (cfg.ext_clk && strobe) |-> (phase == PH_EXT)); // R4
  AST_INT_STROBE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    ($rose(strobe) && !cfg.ext_clk) |-> $past(sar_done)); // R6
  AST_CS_HIGH_NO_RX: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !collecting); // R11
endmodule

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  localparam int W   = 8;
  localparam int DIV = 4;
  localparam int H   = 8;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [W-1:0] vin = '0;
  logic [W-1:0] dac_trial;
  logic cmp_hi, track, dout, dout_oe, strobe, strobe_oe;
  logic [2:0] cfg_chan;
  logic cfg_single, cfg_unipolar, cfg_awake, cfg_ext_clk;
  int checks = 0, errs = 0;

  assign cmp_hi = (vin >= dac_trial);

  always #2 clk = ~clk;

  adc_seq_top #(.RES_W(W), .INT_DIV(DIV)) i_adc_seq_top (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din), .cmp_hi(cmp_hi),
    .dac_trial(dac_trial), .track(track), .dout(dout), .dout_oe(dout_oe),
    .strobe(strobe), .strobe_oe(strobe_oe), .cfg_chan(cfg_chan),
    .cfg_single(cfg_single), .cfg_unipolar(cfg_unipolar), .cfg_awake(cfg_awake),
    .cfg_ext_clk(cfg_ext_clk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk) din = b;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic csel(input logic v);
    @(negedge clk) cs_n = v;
    repeat (H) @(negedge clk);
  endtask

  function automatic logic [7:0] mk(input logic [2:0] ch, input logic uni, input logic ext);
    return {1'b1, ch, uni, uni, 1'b1, ext};
  endfunction

  function automatic logic [W-1:0] code(input logic [W-1:0] v, input logic uni);
    return uni ? v : (v ^ {1'b1, {(W-1){1'b0}}});
  endfunction

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      pulse(b[i]);
      if (i == 3) chk("R3 track before sixth bit", int'(track), 0);
      if (i == 2) chk("R3 track after sixth bit", int'(track), 1);
    end
    chk("R3 hold after eighth bit", int'(track), 0);
    chk("R2 channel field", int'(cfg_chan), int'(b[6:4]));
    chk("R2 unipolar field", int'(cfg_unipolar), int'(b[3]));
    chk("R2 clock field", int'(cfg_ext_clk), int'(b[0]));
  endtask

  task automatic ext_conv(input logic [W-1:0] v, input logic uni, input int lead);
    logic [W-1:0] c;
    c = code(v, uni);
    vin = v;
    csel(1'b0);
    chk("R5 strobe driven low after select", int'({strobe_oe, strobe}), 2);
    for (int k = 0; k < lead; k++) pulse(1'b0);
    send_byte(mk(v[2:0], uni, 1'b1));
    chk("R4 strobe first period", int'(strobe), 1);
    pulse(1'b0);
    chk("R4 strobe second period", int'(strobe), 1);
    for (int k = W - 1; k >= 0; k--) begin
      pulse(1'b0);
      chk("R4 R8 result bit", int'(dout), int'(c[k]));
      if (k == W - 1) chk("R4 strobe ends", int'(strobe), 0);
    end
    pulse(1'b0);
    chk("R4 trailing zero", int'(dout), 0);
    csel(1'b1);
    chk("R5 outputs released", int'({strobe_oe, dout_oe}), 0);
  endtask

  task automatic int_conv(input logic [W-1:0] v, input logic uni);
    logic [W-1:0] c;
    c = code(v, uni);
    vin = v;
    csel(1'b0);
    send_byte(mk(v[2:0], uni, 1'b0));
    chk("R6 strobe low while converting", int'({strobe_oe, strobe}), 2);
    csel(1'b1);
    repeat (8 * DIV + 16) @(negedge clk);
    chk("R6 strobe high at completion", int'({strobe_oe, strobe}), 3);
    chk("R7 dout released with select high", int'(dout_oe), 0);
    csel(1'b0);
    pulse(1'b0);
    chk("R7 first edge after strobe", int'(dout), 0);
    for (int k = W - 1; k >= 0; k--) begin
      pulse(1'b0);
      chk("R7 R8 stored result bit", int'(dout), int'(c[k]));
    end
    pulse(1'b0);
    chk("R7 trailing zero", int'(dout), 0);
    csel(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [W-1:0] c1, c2;
    logic [7:0] b2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 reset enables", int'({strobe_oe, dout_oe, strobe, track}), 0);
    chk("R2 reset clock field", int'(cfg_ext_clk), 1);

    // R11: activity with chip select high
    for (int k = 0; k < 8; k++) pulse(1'b1);
    chk("R11 no frame with select high", int'({track, strobe_oe, cfg_chan}), 0);

    // R1 R4 R8: sweep with varied leading zeros and both codings
    for (int v = 0; v < 256; v += 5) begin
      ext_conv(W'(v), 1'b1, v % 4);
      ext_conv(W'(v), 1'b0, (v + 1) % 4);
    end
    ext_conv(8'hFF, 1'b1, 0);

    // R9: back-to-back frames, early 1 ignored
    vin = 8'h9C;
    c1 = code(vin, 1'b1);
    c2 = code(vin, 1'b0);
    b2 = mk(3'd6, 1'b0, 1'b1);
    csel(1'b0);
    send_byte(mk(3'd3, 1'b1, 1'b1));
    pulse(1'b0);
    pulse(1'b1);
    chk("R9 MSB with early 1 ignored", int'(dout), int'(c1[W-1]));
    for (int i = 7; i >= 0; i--) begin
      pulse(b2[i]);
      if (i > 0) chk("R9 overlapped result bit", int'(dout), int'(c1[i-1]));
    end
    chk("R9 next frame strobe", int'(strobe), 1);
    chk("R9 next frame channel", int'(cfg_chan), 6);
    pulse(1'b0);
    for (int k = W - 1; k >= 0; k--) begin
      pulse(1'b0);
      chk("R9 R8 second result bit", int'(dout), int'(c2[k]));
    end
    csel(1'b1);

    // R10: chip-select toggle cancels a running conversion
    vin = 8'h21;
    csel(1'b0);
    send_byte(mk(3'd1, 1'b1, 1'b1));
    pulse(1'b0);
    csel(1'b1);
    csel(1'b0);
    chk("R5 strobe low after reselect", int'({strobe_oe, strobe}), 2);
    vin = 8'hD3;
    send_byte(mk(3'd5, 1'b1, 1'b1));
    chk("R10 new frame strobe", int'(strobe), 1);
    pulse(1'b0);
    for (int k = W - 1; k >= 0; k--) begin
      pulse(1'b0);
      chk("R10 new result bit", int'(dout), int'(vin[k]));
    end
    csel(1'b1);

    // R6 R7 R8: internal pacing sweep
    for (int v = 3; v < 256; v += 17) begin
      int_conv(W'(v), v[0]);
    end
    int_conv(8'h00, 1'b0);
    int_conv(8'hFF, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule